// File: doc/BRIEF.md
# Scoreboard Issue Controller for Out-of-Order Completion

This block sequences instructions through a small set of functional units without register renaming. Each instruction presented at the single issue port names a unit kind, a destination register and two source registers. The controller gives it a free unit of that kind and records it there. It then grants the operand read once both sources hold valid values, times the execution with a per-unit latency counter, and grants the write-back once no earlier instruction still has to read the old contents of the destination. The arithmetic itself happens elsewhere: this block only produces the grants that the datapath follows.

Every unit slot holds the destination, the two sources, the slot that will produce each pending source, and one ready flag per source. A register ownership table records, for each architectural register, whether a result is still owed to it and by which slot. Instructions issue in program order because there is one issue port and a blocked instruction stays on it. Operand reads and write-backs may then happen in any order the hazards allow.

With the default parameters there are sixteen registers and three slots. Slots 0 and 1 are multipliers (kind 0) with an execute latency of 3 cycles. Slot 2 is an adder (kind 1) with a latency of 1 cycle.

Top module: `ooo_scoreboard`

## Requirements
- R1: In a cycle where `in_valid` is high, an idle unit of kind `in_kind` exists and the destination has no pending writer, `iss_grant` is high in that same cycle. `iss_unit` names the lowest-numbered idle unit of that kind. Kind 0 selects slots 0 and 1, kind 1 selects slot 2.
- R2: While an issued instruction that has not yet written back targets `in_dst`, `iss_grant` stays low. The stall ends in the cycle after that writer's `wb_grant`.
- R3: Issue is in order. A blocked instruction holds the port and `iss_grant` stays low for it, even when a later instruction could have proceeded.
- R4: `rd_grant[u]` rises no earlier than the cycle after issue, and only when both sources are ready. A source is ready at issue if it has no pending writer, or if its writer receives `wb_grant` in that same cycle. Otherwise it becomes ready in the cycle after its writer's `wb_grant`.
- R5: A unit with latency L asks to write back L+1 cycles after its `rd_grant`. With no WAR conflict, `wb_grant` is high in that cycle (rd+4 for a multiplier, rd+2 for the adder).
- R6: `wb_grant[u]` is withheld while another busy unit has a ready but not yet read source equal to unit u's destination. The grant comes in the cycle after that reader's `rd_grant`.
- R7: Each issued instruction receives exactly one `rd_grant`.
- R8: A unit is idle again in the cycle after its `wb_grant` and can accept a new instruction in that cycle.
- R9: Reset returns every unit to idle and clears every pending writer. An instruction presented right after reset issues in cycle 0, even if its destination matched an instruction that was in flight before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented at the issue port |
| in_kind | input | KW | Unit kind required (0 multiplier, 1 adder by default) |
| in_dst | input | RW | Destination register |
| in_src1 | input | RW | First source register |
| in_src2 | input | RW | Second source register |
| iss_grant | output | 1 | The presented instruction issues this cycle |
| iss_unit | output | UW | Slot that receives the issued instruction |
| rd_grant | output | NU | Per-slot operand read grant |
| wb_grant | output | NU | Per-slot result write-back grant |

## Verification
The assertions assume that `in_kind` names a kind that some slot implements and that the fields of the issue port stay unchanged from the cycle `in_valid` rises until `iss_grant` accepts them. The bench drives only kinds 0 and 1 and registers 0 to 15, and changes the port only on the falling clock edge after a grant. Three instruction streams cover the main orderings: a read-after-write chain through both multipliers, a write-back held by a pending reader, and a write-after-write stall together with a producer that writes back in the same cycle its consumer issues. Directed cases then cover the idle state after reset and a reset that discards work still in flight.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_EXEC = 2'd2,
      PH_DONE = 2'd3
   } sb_phase_e;
endpackage

// File: rtl/sb_free_pick.sv
`timescale 1ns/1ps
// Finds the lowest-numbered idle slot whose kind matches the request.
module sb_free_pick #(
   parameter int unsigned NU = 3,
   parameter int unsigned KW = 1,
   parameter int unsigned UW = 2,
   parameter int unsigned UNIT_KIND [NU] = '{0, 0, 1}
) (
   input  logic [NU-1:0] busy,
   input  logic [KW-1:0] kind,
   output logic          found,
   output logic [UW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NU - 1; i >= 0; i--) begin
         if (!busy[i] && (UNIT_KIND[i] == 32'(kind))) begin
            found = 1'b1;
            idx   = UW'(i);
         end
      end
   end
endmodule

// File: rtl/sb_reg_table.sv
`timescale 1ns/1ps
// Register ownership table: one pending bit and one owning slot per register.
module sb_reg_table #(
   parameter int unsigned NREG = 16,
   parameter int unsigned NU   = 3,
   parameter int unsigned RW   = 4,
   parameter int unsigned UW   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_en,
   input  logic [RW-1:0]   set_reg,
   input  logic [UW-1:0]   set_unit,
   input  logic [NU-1:0]   clr_vec,
   input  logic [RW-1:0]   clr_reg [NU],
   output logic [NREG-1:0] pend,
   output logic [UW-1:0]   owner [NREG]
);
   logic [NREG-1:0] pend_n;

   always_comb begin
      pend_n = pend;
      for (int u = 0; u < NU; u++) begin
         if (clr_vec[u]) pend_n[clr_reg[u]] = 1'b0;
      end
      if (set_en) pend_n[set_reg] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         for (int r = 0; r < NREG; r++) owner[r] <= '0;
      end else begin
         pend <= pend_n;
         if (set_en) owner[set_reg] <= set_unit;
      end
   end

   // R2: a register newly claimed is owned by the claiming slot afterwards
   a_r2_claim_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> pend[$past(set_reg)] && (owner[$past(set_reg)] == $past(set_unit)));
endmodule

// File: rtl/sb_unit_slot.sv
`timescale 1ns/1ps
// One functional-unit status slot: phase, register fields, producers,
// ready flags and the execute latency counter.
module sb_unit_slot
   import sb_pkg::*;
#(
   parameter int unsigned NU   = 3,
   parameter int unsigned RW   = 4,
   parameter int unsigned UW   = 2,
   parameter int unsigned LAT  = 1,
   parameter int unsigned SELF = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [RW-1:0] ld_dst,
   input  logic [RW-1:0] ld_s1,
   input  logic [RW-1:0] ld_s2,
   input  logic [UW-1:0] ld_q1,
   input  logic [UW-1:0] ld_q2,
   input  logic          ld_q1v,
   input  logic          ld_q2v,
   input  logic [NU-1:0] wb_vec,
   output logic          busy,
   output logic          rd_go,
   output logic          wb_req,
   output logic          r1,
   output logic          r2,
   output logic [RW-1:0] dst,
   output logic [RW-1:0] s1,
   output logic [RW-1:0] s2
);
   localparam int unsigned CKW = $clog2(LAT + 1);

   sb_phase_e     phase;
   logic [UW-1:0] q1, q2;
   logic          q1v, q2v;
   logic          fin;

   assign busy   = (phase != PH_IDLE);
   assign rd_go  = (phase == PH_WAIT) && r1 && r2;
   assign wb_req = (phase == PH_DONE);

   generate
      if (LAT > 1) begin : g_cnt
         localparam int unsigned CW = $clog2(LAT);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                             cnt <= '0;
            else if (rd_go)                         cnt <= CW'(LAT - 1);
            else if (phase == PH_EXEC && cnt != '0) cnt <= cnt - CW'(1);
         end
         assign fin = (phase == PH_EXEC) && (cnt == '0);
      end else begin : g_one
         assign fin = (phase == PH_EXEC);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         dst   <= '0;
         s1    <= '0;
         s2    <= '0;
         q1    <= '0;
         q2    <= '0;
         q1v   <= 1'b0;
         q2v   <= 1'b0;
         r1    <= 1'b0;
         r2    <= 1'b0;
      end else if (load) begin
         phase <= PH_WAIT;
         dst   <= ld_dst;
         s1    <= ld_s1;
         s2    <= ld_s2;
         q1    <= ld_q1;
         q2    <= ld_q2;
         q1v   <= ld_q1v;
         q2v   <= ld_q2v;
         r1    <= !ld_q1v;
         r2    <= !ld_q2v;
      end else begin
         case (phase)
            PH_WAIT: begin
               if (rd_go) begin
                  phase <= PH_EXEC;
                  r1    <= 1'b0;
                  r2    <= 1'b0;
               end else begin
                  if (q1v && wb_vec[q1]) begin
                     r1  <= 1'b1;
                     q1v <= 1'b0;
                  end
                  if (q2v && wb_vec[q2]) begin
                     r2  <= 1'b1;
                     q2v <= 1'b0;
                  end
               end
            end
            PH_EXEC: if (fin) phase <= PH_DONE;
            PH_DONE: if (wb_vec[SELF]) phase <= PH_IDLE;
            default: ;
         endcase
      end
   end

   // checker-side count of execute cycles
   logic [CKW-1:0] ck;
   always_ff @(posedge clk) begin
      if (!rst_n)                         ck <= '0;
      else if (rd_go)                     ck <= '0;
      else if (phase == PH_EXEC && !fin)  ck <= ck + CKW'(1);
   end

   // R4: operand read only once no producer is still owed
   a_r4_src_settled: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |-> !q1v && !q2v);
   // R5: execution spans exactly LAT cycles, then write-back is requested
   a_r5_exec_len: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> ck == CKW'(LAT - 1));
   a_r5_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> wb_req);
   // R7: a single operand read per instruction
   a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |=> !rd_go);
   // R8: slot is idle right after its write-back
   a_r8_idle_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && wb_vec[SELF]) |=> !busy);
endmodule

// File: rtl/sb_war_gate.sv
`timescale 1ns/1ps
// Grants write-back unless another slot still has to read the old value.
module sb_war_gate #(
   parameter int unsigned NU = 3,
   parameter int unsigned RW = 4
) (
   input  logic [NU-1:0] wb_req,
   input  logic [NU-1:0] busy,
   input  logic [NU-1:0] r1,
   input  logic [NU-1:0] r2,
   input  logic [RW-1:0] dst [NU],
   input  logic [RW-1:0] s1 [NU],
   input  logic [RW-1:0] s2 [NU],
   output logic [NU-1:0] wb_grant
);
   logic [NU-1:0] hazard;

   always_comb begin
      hazard = '0;
      for (int u = 0; u < NU; u++) begin
         for (int v = 0; v < NU; v++) begin
            if (v != u && busy[v] &&
                ((r1[v] && s1[v] == dst[u]) || (r2[v] && s2[v] == dst[u])))
               hazard[u] = 1'b1;
         end
      end
      wb_grant = wb_req & ~hazard;
   end
endmodule

// File: rtl/ooo_scoreboard.sv
`timescale 1ns/1ps
module ooo_scoreboard #(
   parameter int unsigned NREG  = 16,
   parameter int unsigned NU    = 3,
   parameter int unsigned NKIND = 2,
   parameter int unsigned UNIT_KIND [NU] = '{0, 0, 1},
   parameter int unsigned UNIT_LAT  [NU] = '{3, 3, 1},
   localparam int unsigned RW = $clog2(NREG),
   localparam int unsigned UW = (NU > 1) ? $clog2(NU) : 1,
   localparam int unsigned KW = (NKIND > 1) ? $clog2(NKIND) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [KW-1:0] in_kind,
   input  logic [RW-1:0] in_dst,
   input  logic [RW-1:0] in_src1,
   input  logic [RW-1:0] in_src2,
   output logic          iss_grant,
   output logic [UW-1:0] iss_unit,
   output logic [NU-1:0] rd_grant,
   output logic [NU-1:0] wb_grant
);
   if (NREG < 2) begin : g_bad_nreg
      $error("NREG must be at least 2");
   end
   if (NU < 1) begin : g_bad_nu
      $error("NU must be at least 1");
   end

   logic          found;
   logic [UW-1:0] pick;
   logic [NREG-1:0] pend;
   logic [UW-1:0]   owner [NREG];
   logic [NU-1:0]   s_busy, s_wbreq, s_r1, s_r2;
   logic [RW-1:0]   s_dst [NU];
   logic [RW-1:0]   s_s1  [NU];
   logic [RW-1:0]   s_s2  [NU];
   logic [UW-1:0]   q1, q2;
   logic            q1v, q2v;

   sb_free_pick #(.NU(NU), .KW(KW), .UW(UW), .UNIT_KIND(UNIT_KIND)) u_pick (
      .busy(s_busy), .kind(in_kind), .found(found), .idx(pick));

   assign iss_grant = in_valid && found && !pend[in_dst];
   assign iss_unit  = pick;

   // a source whose producer writes back this very cycle is already ready
   assign q1  = owner[in_src1];
   assign q2  = owner[in_src2];
   assign q1v = pend[in_src1] && !wb_grant[q1];
   assign q2v = pend[in_src2] && !wb_grant[q2];

   sb_reg_table #(.NREG(NREG), .NU(NU), .RW(RW), .UW(UW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .set_en(iss_grant), .set_reg(in_dst), .set_unit(pick),
      .clr_vec(wb_grant), .clr_reg(s_dst),
      .pend(pend), .owner(owner));

   for (genvar g = 0; g < NU; g++) begin : g_slot
      if (UNIT_KIND[g] >= NKIND || UNIT_LAT[g] < 1) begin : g_bad_cfg
         $error("slot kind out of range or zero latency");
      end
      sb_unit_slot #(.NU(NU), .RW(RW), .UW(UW), .LAT(UNIT_LAT[g]), .SELF(g)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .load(iss_grant && (pick == UW'(g))),
         .ld_dst(in_dst), .ld_s1(in_src1), .ld_s2(in_src2),
         .ld_q1(q1), .ld_q2(q2), .ld_q1v(q1v), .ld_q2v(q2v),
         .wb_vec(wb_grant),
         .busy(s_busy[g]), .rd_go(rd_grant[g]), .wb_req(s_wbreq[g]),
         .r1(s_r1[g]), .r2(s_r2[g]),
         .dst(s_dst[g]), .s1(s_s1[g]), .s2(s_s2[g]));
   end

   sb_war_gate #(.NU(NU), .RW(RW)) u_war (
      .wb_req(s_wbreq), .busy(s_busy), .r1(s_r1), .r2(s_r2),
      .dst(s_dst), .s1(s_s1), .s2(s_s2), .wb_grant(wb_grant));

   // R1: grant goes to an idle slot of the requested kind
   a_r1_kind_match: assert property (@(posedge clk) disable iff (!rst_n)
      iss_grant |-> (UNIT_KIND[iss_unit] == 32'(in_kind)) && !s_busy[iss_unit]);

   for (genvar u = 0; u < NU; u++) begin : g_pair_u
      for (genvar v = 0; v < NU; v++) begin : g_pair_v
         if (u != v) begin : g_chk
            // R2: two in-flight instructions never share a destination
            a_r2_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
               (s_busy[u] && s_busy[v]) |-> s_dst[u] != s_dst[v]);
            // R6: no write-back while another slot still reads the old value
            a_r6_no_pending_reader: assert property (@(posedge clk) disable iff (!rst_n)
               (wb_grant[u] && s_busy[v]) |->
                  !((s_r1[v] && s_s1[v] == s_dst[u]) || (s_r2[v] && s_s2[v] == s_dst[u])));
         end
      end
   end
endmodule

// File: tb/sim_ooo_scoreboard.sv
`timescale 1ns/1ps
module sim_ooo_scoreboard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [0:0] in_kind = '0;
   logic [3:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
   logic       iss_grant;
   logic [1:0] iss_unit;
   logic [2:0] rd_grant, wb_grant;

   int checks = 0;
   int errors = 0;
   int wd = 0;

   always #5 clk = ~clk;

   ooo_scoreboard u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
      .iss_grant(iss_grant), .iss_unit(iss_unit),
      .rd_grant(rd_grant), .wb_grant(wb_grant));

   typedef struct packed {
      logic [0:0] kind;
      logic [3:0] dst;
      logic [3:0] s1;
      logic [3:0] s2;
      logic [5:0] e_iss;
      logic [1:0] e_unit;
      logic [5:0] e_rd;
      logic [5:0] e_wb;
   } row_t;

   localparam int NROW = 14;
   // kind 0 = multiplier (slots 0,1, latency 3); kind 1 = adder (slot 2, latency 1)
   localparam row_t TBL [NROW] = '{
      // stream A: RAW chain, adder WAR hold, adder busy plus WAW stall
      '{1'd0, 4'd4,  4'd0,  4'd2,  6'd0,  2'd0, 6'd1,  6'd5},
      '{1'd0, 4'd6,  4'd4,  4'd8,  6'd1,  2'd1, 6'd6,  6'd10},
      '{1'd1, 4'd8,  4'd2,  4'd12, 6'd2,  2'd2, 6'd3,  6'd7},
      '{1'd1, 4'd4,  4'd14, 4'd15, 6'd8,  2'd2, 6'd9,  6'd11},
      // stream B: two producers for one adder, slot reuse
      '{1'd0, 4'd1,  4'd2,  4'd3,  6'd0,  2'd0, 6'd1,  6'd5},
      '{1'd0, 4'd7,  4'd8,  4'd9,  6'd1,  2'd1, 6'd2,  6'd6},
      '{1'd1, 4'd4,  4'd1,  4'd7,  6'd2,  2'd2, 6'd7,  6'd9},
      '{1'd0, 4'd10, 4'd4,  4'd4,  6'd6,  2'd0, 6'd10, 6'd14},
      '{1'd1, 4'd11, 4'd10, 4'd0,  6'd10, 2'd2, 6'd15, 6'd17},
      // stream C: same-cycle bypass, WAW stall, in-order blocking
      '{1'd0, 4'd3,  4'd1,  4'd2,  6'd0,  2'd0, 6'd1,  6'd5},
      '{1'd1, 4'd4,  4'd1,  4'd2,  6'd1,  2'd2, 6'd2,  6'd4},
      '{1'd1, 4'd5,  4'd3,  4'd3,  6'd5,  2'd2, 6'd6,  6'd8},
      '{1'd0, 4'd5,  4'd1,  4'd1,  6'd9,  2'd0, 6'd10, 6'd14},
      '{1'd1, 4'd7,  4'd1,  4'd1,  6'd10, 2'd2, 6'd11, 6'd13}
   };
   localparam int WIN = 24;

   int iss_obs [NROW];
   int unit_obs[NROW];
   int rd_obs  [NROW];
   int wb_obs  [NROW];
   int rd_cnt  [NROW];

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_stream(input int first, input int n);
      int ptr;
      int occ [3];
      ptr = first;
      for (int u = 0; u < 3; u++) occ[u] = first;
      do_reset();
      for (int cyc = 0; cyc < WIN; cyc++) begin
         @(negedge clk);
         if (ptr < first + n) begin
            in_valid = 1'b1;
            in_kind  = TBL[ptr].kind;
            in_dst   = TBL[ptr].dst;
            in_src1  = TBL[ptr].s1;
            in_src2  = TBL[ptr].s2;
         end else begin
            in_valid = 1'b0;
         end
         #1;
         if (in_valid && iss_grant) begin
            iss_obs[ptr]  = cyc;
            unit_obs[ptr] = int'(iss_unit);
            occ[iss_unit] = ptr;
            ptr++;
         end
         for (int u = 0; u < 3; u++) begin
            if (rd_grant[u]) begin
               rd_obs[occ[u]] = cyc;
               rd_cnt[occ[u]]++;
            end
            if (wb_grant[u]) wb_obs[occ[u]] = cyc;
         end
      end
      in_valid = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < NROW; i++) begin
         iss_obs[i] = 63; unit_obs[i] = 3; rd_obs[i] = 63; wb_obs[i] = 63; rd_cnt[i] = 0;
      end

      // R9: idle state after reset
      do_reset();
      @(negedge clk); #1;
      check("R9 reset iss_grant", int'(iss_grant), 0);
      check("R9 reset rd_grant", int'(rd_grant), 0);
      check("R9 reset wb_grant", int'(wb_grant), 0);
      // R1: adder request issues at once to slot 2
      in_valid = 1'b1; in_kind = 1'b1; in_dst = 4'd9; in_src1 = 4'd1; in_src2 = 4'd2;
      #1;
      check("R1 idle adder grant", int'(iss_grant), 1);
      check("R1 idle adder unit", int'(iss_unit), 2);
      in_valid = 1'b0;

      // table of instruction streams
      run_stream(0, 4);
      run_stream(4, 5);
      run_stream(9, 5);
      for (int i = 0; i < NROW; i++) begin
         check($sformatf("R1/R2/R3/R8 issue cycle row %0d", i), iss_obs[i], int'(TBL[i].e_iss));
         check($sformatf("R1 issue unit row %0d", i), unit_obs[i], int'(TBL[i].e_unit));
         check($sformatf("R4 read cycle row %0d", i), rd_obs[i], int'(TBL[i].e_rd));
         check($sformatf("R5/R6 write-back cycle row %0d", i), wb_obs[i], int'(TBL[i].e_wb));
         check($sformatf("R7 read count row %0d", i), rd_cnt[i], 1);
      end

      // R9: reset discards an in-flight writer of R3
      do_reset();
      @(negedge clk);
      in_valid = 1'b1; in_kind = 1'b0; in_dst = 4'd3; in_src1 = 4'd0; in_src2 = 4'd0;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      do_reset();
      @(negedge clk); #1;
      check("R9 in-flight cleared rd_grant", int'(rd_grant), 0);
      check("R9 in-flight cleared wb_grant", int'(wb_grant), 0);
      in_valid = 1'b1; in_kind = 1'b0; in_dst = 4'd3;
      #1;
      check("R9 no stale WAW grant", int'(iss_grant), 1);
      check("R9 no stale WAW unit", int'(iss_unit), 0);
      in_valid = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 5000) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1..R9 run: actual=%0d expected<=5000 cycles", wd);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule